// File: doc/BRIEF.md
# Split-Half Vector Register Rename Map

This block renames a file of architectural 256-bit vector registers onto a shared pool of 128-bit physical registers. Each architectural register is tracked as two halves, lower and upper. Each half either points at its own physical tag or carries a zero flag that says it holds all zeros and owns no physical storage. A rename request for a full-width write takes two tags. A half-width write takes one tag for the lower half and either keeps the upper half or marks it zero. Two bulk commands clear every upper half, or every half. They hand all storage those halves held back to the free pool in one cycle, so later 128-bit-only code has more registers to rename into.

The free pool is a bitmap that gives out tags lowest index first. A rename that needs more tags than are free is refused by holding ready low. Source lookups are combinational: given an architectural register, they return a tag and a zero indication for each half.

Top module: `vec_half_rename`

## Requirements
- R1: After reset every half of every architectural register reads as zero, and every physical register is free, so the first full-width rename receives tags 0 and 1.
- R2: An accepted full-width write (op code 0) takes the lowest free tag for the lower half and the next-lowest for the upper half, both shown on the destination outputs in the request cycle. From the next cycle both halves of that register look up as those tags with zero flags clear.
- R3: An accepted lower write that zeroes the upper half (op code 1) takes the lowest free tag for the lower half. Afterwards the upper half reads as zero.
- R4: An accepted lower write that keeps the upper half (op code 2) takes the lowest free tag and remaps only the lower half. The upper tag and zero flag are left as they were.
- R5: Every tag displaced by a write or by a zero command goes back to the pool. It can be handed out from the cycle after the release, not in the release cycle.
- R6: The zero-upper command (op code 3) takes one cycle. It marks the upper half of every register as zero and frees every tag held by an upper half. Lower halves are unchanged.
- R7: The zero-all command (op code 4) takes one cycle. It marks both halves of every register as zero and frees every tag they held.
- R8: A lookup of a half whose zero flag is set returns the zero indication high and a tag of 0.
- R9: Ready is low when a full-width write finds fewer than two free tags, or a lower write finds none. A request presented while ready is low changes nothing. Zero commands and the unused op codes 5 to 7 are always ready, and the unused codes change nothing.
- R10: A lookup in the same cycle as a rename of that register returns the mapping from before the rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request code: 0 full write, 1 lower write zeroing upper, 2 lower write keeping upper, 3 zero-upper, 4 zero-all |
| req_arch | input | $clog2(NUM_ARCH) | Architectural destination register |
| req_ready | output | 1 | Request can be accepted this cycle |
| dst_lo_tag | output | $clog2(NUM_PHYS) | Tag given to the lower half |
| dst_hi_tag | output | $clog2(NUM_PHYS) | Tag given to the upper half (full write) |
| src_arch | input | $clog2(NUM_ARCH) | Architectural register to look up |
| src_lo_tag | output | $clog2(NUM_PHYS) | Lower-half tag, 0 when zero |
| src_lo_zero | output | 1 | Lower half is known zero |
| src_hi_tag | output | $clog2(NUM_PHYS) | Upper-half tag, 0 when zero |
| src_hi_zero | output | 1 | Upper half is known zero |

## Verification
Some properties are checked on every cycle. Tags held by non-zero halves plus free tags always add up to the pool size, so no tag is leaked or owned twice. A release never targets a tag that is already free. Each zero command leaves the matching flags set on the next edge, and a refused request leaves the map still. Only the bench's scenarios can show the lowest-first tag values, that released tags stay out of reach until the next cycle, that lookups return the pre-rename mapping, and what happens when the pool runs dry and a zero command then refills it.

// File: rtl/vhr_pkg.sv
package vhr_pkg;

    typedef enum logic [2:0] {
        OP_FULL     = 3'd0,
        OP_LO_ZU    = 3'd1,
        OP_LO_KEEP  = 3'd2,
        OP_ZERO_UP  = 3'd3,
        OP_ZERO_ALL = 3'd4
    } vhr_op_e;

    // Number of fresh tags a request code consumes.
    function automatic logic [1:0] op_need(input logic [2:0] op);
        case (op)
            OP_FULL:              return 2'd2;
            OP_LO_ZU, OP_LO_KEEP: return 2'd1;
            default:              return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/vhr_pick_lowest.sv
module vhr_pick_lowest #(
    parameter int N  = 64,
    parameter int TW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [TW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = TW'(i);
            end
        end
    end
endmodule

// File: rtl/vhr_free_pool.sv
module vhr_free_pool #(
    parameter int NUM_PHYS = 64,
    parameter int TW       = $clog2(NUM_PHYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take0,
    input  logic                take1,
    input  logic [NUM_PHYS-1:0] rel_mask,
    output logic [TW-1:0]       pick0,
    output logic [TW-1:0]       pick1,
    output logic                have0,
    output logic                have1,
    output logic [NUM_PHYS-1:0] free_o
);
    logic [NUM_PHYS-1:0] free_q, free_d;
    logic [NUM_PHYS-1:0] cand1;

    vhr_pick_lowest #(.N(NUM_PHYS), .TW(TW)) u_pick0 (
        .vec(free_q), .found(have0), .idx(pick0)
    );

    always_comb begin
        cand1        = free_q;
        cand1[pick0] = 1'b0;
    end

    vhr_pick_lowest #(.N(NUM_PHYS), .TW(TW)) u_pick1 (
        .vec(cand1), .found(have1), .idx(pick1)
    );

    // Releases enter free_d only, so they are pickable next cycle.
    always_comb begin
        free_d = free_q;
        if (take0) free_d[pick0] = 1'b0;
        if (take1) free_d[pick1] = 1'b0;
        free_d = free_d | rel_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= free_d;
    end

    assign free_o = free_q;

    // R5: a released tag must be one the map owned, never a free one.
    a_r5_release_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_mask & free_q) == '0);

    // R9: the top may only take a second tag when one exists.
    a_r9_take_available: assert property (@(posedge clk) disable iff (!rst_n)
        take1 |-> have1);

endmodule

// File: rtl/vec_half_rename.sv
module vec_half_rename
    import vhr_pkg::*;
#(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 64,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_arch,
    output logic          req_ready,
    output logic [TW-1:0] dst_lo_tag,
    output logic [TW-1:0] dst_hi_tag,
    input  logic [AW-1:0] src_arch,
    output logic [TW-1:0] src_lo_tag,
    output logic          src_lo_zero,
    output logic [TW-1:0] src_hi_tag,
    output logic          src_hi_zero
);
    typedef struct packed {
        logic [NUM_ARCH-1:0]         lo_z;
        logic [NUM_ARCH-1:0]         hi_z;
        logic [NUM_ARCH-1:0][TW-1:0] lo_tag;
        logic [NUM_ARCH-1:0][TW-1:0] hi_tag;
    } map_t;

    map_t                st_q, st_d;
    logic [NUM_PHYS-1:0] rel_mask, free_vec;
    logic [TW-1:0]       pick0, pick1;
    logic                have0, have1, take0, take1, accept;
    logic [1:0]          need;

    vhr_free_pool #(.NUM_PHYS(NUM_PHYS), .TW(TW)) u_pool (
        .clk(clk), .rst_n(rst_n), .take0(take0), .take1(take1),
        .rel_mask(rel_mask), .pick0(pick0), .pick1(pick1),
        .have0(have0), .have1(have1), .free_o(free_vec)
    );

    always_comb begin
        need      = op_need(req_op);
        req_ready = (need == 2'd0) || (need == 2'd1 ? have0 : have1);
        accept    = req_valid && req_ready;
        take0     = accept && (need != 2'd0);
        take1     = accept && (need == 2'd2);
        st_d      = st_q;
        rel_mask  = '0;
        if (accept) begin
            case (vhr_op_e'(req_op))
                OP_FULL: begin
                    if (!st_q.lo_z[req_arch]) rel_mask[st_q.lo_tag[req_arch]] = 1'b1;
                    if (!st_q.hi_z[req_arch]) rel_mask[st_q.hi_tag[req_arch]] = 1'b1;
                    st_d.lo_tag[req_arch] = pick0;
                    st_d.hi_tag[req_arch] = pick1;
                    st_d.lo_z[req_arch]   = 1'b0;
                    st_d.hi_z[req_arch]   = 1'b0;
                end
                OP_LO_ZU: begin
                    if (!st_q.lo_z[req_arch]) rel_mask[st_q.lo_tag[req_arch]] = 1'b1;
                    if (!st_q.hi_z[req_arch]) rel_mask[st_q.hi_tag[req_arch]] = 1'b1;
                    st_d.lo_tag[req_arch] = pick0;
                    st_d.hi_tag[req_arch] = '0;
                    st_d.lo_z[req_arch]   = 1'b0;
                    st_d.hi_z[req_arch]   = 1'b1;
                end
                OP_LO_KEEP: begin
                    if (!st_q.lo_z[req_arch]) rel_mask[st_q.lo_tag[req_arch]] = 1'b1;
                    st_d.lo_tag[req_arch] = pick0;
                    st_d.lo_z[req_arch]   = 1'b0;
                end
                OP_ZERO_UP: begin
                    for (int i = 0; i < NUM_ARCH; i++) begin
                        if (!st_q.hi_z[i]) rel_mask[st_q.hi_tag[i]] = 1'b1;
                    end
                    st_d.hi_z   = '1;
                    st_d.hi_tag = '0;
                end
                OP_ZERO_ALL: begin
                    for (int i = 0; i < NUM_ARCH; i++) begin
                        if (!st_q.hi_z[i]) rel_mask[st_q.hi_tag[i]] = 1'b1;
                        if (!st_q.lo_z[i]) rel_mask[st_q.lo_tag[i]] = 1'b1;
                    end
                    st_d.hi_z   = '1;
                    st_d.lo_z   = '1;
                    st_d.hi_tag = '0;
                    st_d.lo_tag = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lo_z   <= '1;
            st_q.hi_z   <= '1;
            st_q.lo_tag <= '0;
            st_q.hi_tag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_lo_tag  = pick0;
    assign dst_hi_tag  = pick1;
    assign src_lo_zero = st_q.lo_z[src_arch];
    assign src_hi_zero = st_q.hi_z[src_arch];
    assign src_lo_tag  = src_lo_zero ? '0 : st_q.lo_tag[src_arch];
    assign src_hi_tag  = src_hi_zero ? '0 : st_q.hi_tag[src_arch];

    // R5: owned halves plus free tags always account for the whole pool.
    a_r5_tag_conservation: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~st_q.lo_z) + $countones(~st_q.hi_z) + $countones(free_vec)) == NUM_PHYS);

    a_r2_full_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_FULL) |=>
            (!st_q.lo_z[$past(req_arch)] && !st_q.hi_z[$past(req_arch)]));

    a_r6_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_ZERO_UP) |=> (&st_q.hi_z));

    a_r7_zero_all: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_ZERO_ALL) |=> ((&st_q.hi_z) && (&st_q.lo_z)));

    a_r9_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(st_q));

endmodule

// File: tb/vec_half_rename_tb.sv
module vec_half_rename_tb;
    localparam int NA = 16;
    localparam int NP = 32;
    localparam int AW = 4;
    localparam int TW = 5;
    localparam int NT = 14;
    // {op[6:4], arch[3:0]}
    localparam logic [6:0] TBL [NT] = '{
        {3'd0, 4'd3}, {3'd1, 4'd5}, {3'd2, 4'd5}, {3'd0, 4'd3},
        {3'd2, 4'd7}, {3'd0, 4'd9}, {3'd3, 4'd0}, {3'd0, 4'd0},
        {3'd6, 4'd0}, {3'd4, 4'd0}, {3'd1, 4'd1}, {3'd0, 4'd2},
        {3'd2, 4'd2}, {3'd3, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_arch = '0;
    logic [AW-1:0] src_arch = '0;
    logic req_ready, src_lo_zero, src_hi_zero;
    logic [TW-1:0] dst_lo_tag, dst_hi_tag, src_lo_tag, src_hi_tag;

    always #5 clk = ~clk;

    vec_half_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_arch(req_arch), .req_ready(req_ready), .dst_lo_tag(dst_lo_tag),
        .dst_hi_tag(dst_hi_tag), .src_arch(src_arch), .src_lo_tag(src_lo_tag),
        .src_lo_zero(src_lo_zero), .src_hi_tag(src_hi_tag), .src_hi_zero(src_hi_zero)
    );

    int m_lo [NA];
    int m_hi [NA];
    bit m_lz [NA];
    bit m_hz [NA];
    bit m_free [NP];
    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lowest(input int skip);
        for (int i = 0; i < NP; i++) if (m_free[i] && i != skip) return i;
        return -1;
    endfunction

    task automatic cmp_lookup(input int a, input string req);
        chk({req, " lo_zero"}, int'(src_lo_zero), int'(m_lz[a]));
        chk({req, " hi_zero"}, int'(src_hi_zero), int'(m_hz[a]));
        chk({req, " lo_tag"}, int'(src_lo_tag), m_lz[a] ? 0 : m_lo[a]);
        chk({req, " hi_tag"}, int'(src_hi_tag), m_hz[a] ? 0 : m_hi[a]);
    endtask

    task automatic check_map(input int a, input string req);
        @(negedge clk);
        src_arch = AW'(a);
        #1;
        cmp_lookup(a, req);
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < NA; a++) check_map(a, req);
    endtask

    task automatic do_op(input int op, input int a);
        int p0, p1, need;
        bit rdy;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_arch  = AW'(a);
        src_arch  = AW'(a);
        #1;
        p0   = lowest(-1);
        p1   = (p0 < 0) ? -1 : lowest(p0);
        need = (op == 0) ? 2 : ((op == 1 || op == 2) ? 1 : 0);
        rdy  = (need == 0) || (need == 1 ? p0 >= 0 : p1 >= 0);
        chk("R9 ready", int'(req_ready), int'(rdy));
        if (rdy && need >= 1) chk("R2/R3/R4/R5 lower tag", int'(dst_lo_tag), p0);
        if (rdy && need == 2) chk("R2/R5 upper tag", int'(dst_hi_tag), p1);
        cmp_lookup(a, "R10 pre-rename lookup");
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (rdy) begin
            case (op)
                0: begin
                    if (!m_lz[a]) m_free[m_lo[a]] = 1'b1;
                    if (!m_hz[a]) m_free[m_hi[a]] = 1'b1;
                    m_free[p0] = 1'b0; m_free[p1] = 1'b0;
                    m_lo[a] = p0; m_hi[a] = p1; m_lz[a] = 1'b0; m_hz[a] = 1'b0;
                end
                1: begin
                    if (!m_lz[a]) m_free[m_lo[a]] = 1'b1;
                    if (!m_hz[a]) m_free[m_hi[a]] = 1'b1;
                    m_free[p0] = 1'b0;
                    m_lo[a] = p0; m_lz[a] = 1'b0; m_hz[a] = 1'b1; m_hi[a] = 0;
                end
                2: begin
                    if (!m_lz[a]) m_free[m_lo[a]] = 1'b1;
                    m_free[p0] = 1'b0;
                    m_lo[a] = p0; m_lz[a] = 1'b0;
                end
                3: for (int i = 0; i < NA; i++) begin
                    if (!m_hz[i]) m_free[m_hi[i]] = 1'b1;
                    m_hz[i] = 1'b1; m_hi[i] = 0;
                end
                4: for (int i = 0; i < NA; i++) begin
                    if (!m_hz[i]) m_free[m_hi[i]] = 1'b1;
                    if (!m_lz[i]) m_free[m_lo[i]] = 1'b1;
                    m_hz[i] = 1'b1; m_lz[i] = 1'b1; m_hi[i] = 0; m_lo[i] = 0;
                end
                default: ;
            endcase
        end
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NA; i++) begin
            m_lo[i] = 0; m_hi[i] = 0; m_lz[i] = 1'b1; m_hz[i] = 1'b1;
        end
        for (int i = 0; i < NP; i++) m_free[i] = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, all halves zero (R8 zero indication), pool full
        check_all("R1/R8 reset");
        #1 chk("R1 ready after reset", int'(req_ready), 1);

        // Vector table walk
        for (int k = 0; k < NT; k++) begin
            int op, a;
            op = int'(TBL[k][6:4]);
            a  = int'(TBL[k][3:0]);
            do_op(op, a);
            case (op)
                0: check_map(a, "R2 after full write");
                1: check_map(a, "R3/R8 after zero-upper write");
                2: check_map(a, "R4 after keep-upper write");
                3: check_all("R6/R8 after zero-upper");
                4: check_all("R7/R8 after zero-all");
                default: check_map(a, "R9 unused code no effect");
            endcase
        end

        // Exhaust the pool: 16 full writes take all 32 tags
        do_op(4, 0);
        for (int a = 0; a < NA; a++) do_op(0, a);
        check_all("R2 pool filled");
        do_op(0, 4);
        check_map(4, "R9 refused full write no effect");
        do_op(2, 4);
        check_map(4, "R9 refused lower write no effect");
        // Zero-upper refills half the pool in one cycle
        do_op(3, 0);
        check_all("R6 upper release");
        do_op(0, 4);
        check_map(4, "R5 reuse of released tags");
        do_op(1, 9);
        check_map(9, "R3 after refill");
        do_op(2, 11);
        check_map(11, "R4 keep upper zero");
        do_op(4, 0);
        check_all("R7 final zero-all");
        do_op(0, 15);
        check_map(15, "R5 R7 reuse after zero-all");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule